// File: doc/BRIEF.md
# System Configuration Register Bank

This block holds seven 32-bit system configuration words behind a simple word-wide bus with separate read and write strobes. Every word has its own bit policy: some bits are ordinary storage, some are tied to zero, some can only be set, some can only be cleared, and one error flag is raised by hardware and cleared by software writing a one. The contents of every word are driven out on dedicated ports, so the logic that acts on these controls lives outside the block.

Writes take effect on the rising clock edge where the write strobe is high. Reads are registered: the word selected while the read strobe is high appears on the read data port one cycle later. Byte enables are not provided, so every write covers the whole word.

Top module: `cfgreg_bank`

## Requirements
- R1: After reset every word reads 0x00000000 except the system word 1 (byte offset 0x04), which reads 0x7C000001.
- R2: A read with the strobe high in cycle N returns the word on bus_rdata after the edge ending cycle N. After an edge with the read strobe low, bus_rdata is 0.
- R3: The remap word (offset 0x00) stores only bits 8 and 2:0 (mask 0x00000107) as ordinary read/write bits. All other bits read 0 whatever is written.
- R4: System word 1 (offset 0x04) stores bits under mask 0xFCFF0100 as ordinary read/write bits. Bits 25:24, 15:9 and 7:1 read 0. Bits 30:26 reset to one and can be written to zero.
- R5: Bit 0 of system word 1 is clear-only. A write with bit 0 at 0 clears it, and no later write can set it before reset.
- R6: Bits 3:0 of system word 2 (offset 0x1C) are set-only. A 1 written sets the bit. A 0 written leaves it as it was.
- R7: Bit 8 of system word 2 is an error flag. A write never sets it, and a write with bit 8 at 1 clears it. A one-cycle pulse on err_evt sets it. If the pulse and a clearing write fall in the same cycle, the flag ends set.
- R8: The two write-protect words (offsets 0x20 and 0x28) are set-only in all 32 bits. A bit stays at 1 until reset.
- R9: The key word (offset 0x24) stores bits 7:0 as ordinary read/write bits. Bits 31:8 read 0.
- R10: The status/control word (offset 0x18) stores bit 0 as an ordinary read/write bit. Bits 31:1 read 0.
- R11: Any address that is not exactly one of the seven offsets reads 0, and a write to it changes no word. This includes 0x08 through 0x14, misaligned addresses, and 0x2C and above.
- R12: Each word's output port shows the stored value from the edge on which a write to it takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| err_evt | input | 1 | Hardware pulse that raises the error flag |
| cfg_remap | output | 32 | Remap word |
| cfg_sys1 | output | 32 | System word 1 |
| cfg_stat | output | 32 | Status/control word |
| cfg_sys2 | output | 32 | System word 2 |
| cfg_wprot_a | output | 32 | Write-protect word A |
| cfg_key | output | 32 | Key word |
| cfg_wprot_b | output | 32 | Write-protect word B |

## Verification
The assertions assume that the reset is applied synchronously for at least one edge before any access. They also assume that address, strobes, write data and err_evt are stable around the rising edge. They do not assume that reads and writes are exclusive. A set-only or clear-only bit must hold its direction on every edge, whatever the bus does. The stimulus drives every input on the falling edge, raises at most one strobe per cycle in most scenarios, and holds err_evt for a single cycle, once alone and once together with a clearing write.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned NREG   = 7;
   typedef logic [DATA_W-1:0] word_t;

   // slot indices
   localparam int unsigned IX_REMAP = 0;
   localparam int unsigned IX_SYS1  = 1;
   localparam int unsigned IX_STAT  = 2;
   localparam int unsigned IX_SYS2  = 3;
   localparam int unsigned IX_WPA   = 4;
   localparam int unsigned IX_KEY   = 5;
   localparam int unsigned IX_WPB   = 6;

   localparam word_t OFS_TAB [NREG] = '{32'h00, 32'h04, 32'h18, 32'h1C,
                                        32'h20, 32'h24, 32'h28};
   localparam word_t RW_TAB  [NREG] = '{32'h0000_0107, 32'hFCFF_0100, 32'h0000_0001,
                                        32'h0000_0000, 32'h0000_0000, 32'h0000_00FF,
                                        32'h0000_0000};
   localparam word_t SO_TAB  [NREG] = '{32'h0, 32'h0, 32'h0, 32'h0000_000F,
                                        32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF};
   localparam word_t CO_TAB  [NREG] = '{32'h0, 32'h0000_0001, 32'h0, 32'h0,
                                        32'h0, 32'h0, 32'h0};
   localparam word_t W1C_TAB [NREG] = '{32'h0, 32'h0, 32'h0, 32'h0000_0100,
                                        32'h0, 32'h0, 32'h0};
   localparam word_t RST_TAB [NREG] = '{32'h0, 32'h7C00_0001, 32'h0, 32'h0,
                                        32'h0, 32'h0, 32'h0};
endpackage

// File: rtl/cfgreg_decode.sv
module cfgreg_decode
   import cfgreg_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NREG-1:0]   sel,
   output logic              hit
);
   if (ADDR_W < 6 || ADDR_W > 32) begin : g_bad_aw
      $error("cfgreg_decode: ADDR_W must lie in 6..32");
   end

   for (genvar i = 0; i < NREG; i++) begin : g_cmp
      localparam word_t OFS = OFS_TAB[i];
      assign sel[i] = (addr == OFS[ADDR_W-1:0]);
   end

   assign hit = |sel;
endmodule

// File: rtl/cfgreg_cell.sv
module cfgreg_cell #(
   parameter int unsigned W     = 32,
   parameter logic [W-1:0] RW_M  = '0,
   parameter logic [W-1:0] SO_M  = '0,
   parameter logic [W-1:0] CO_M  = '0,
   parameter logic [W-1:0] W1C_M = '0,
   parameter logic [W-1:0] RST_V = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] hw_set,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] STORE_M = RW_M | SO_M | CO_M | W1C_M;

   if (((RW_M & SO_M) | (RW_M & CO_M) | (RW_M & W1C_M) |
        (SO_M & CO_M) | (SO_M & W1C_M) | (CO_M & W1C_M)) != '0) begin : g_bad_ovl
      $error("cfgreg_cell: access masks overlap");
   end
   if ((RST_V & ~STORE_M) != '0) begin : g_bad_rst
      $error("cfgreg_cell: reset value sets an unstored bit");
   end

   logic [W-1:0] wset, nxt;
   assign wset = wr_en ? wdata : '0;

   always_comb begin
      nxt = ((wr_en ? wdata : q) & RW_M)
          | ((q | wset) & SO_M)
          | (q & (wr_en ? wdata : '1) & CO_M)
          | (((q & ~wset) | hw_set) & W1C_M);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= RST_V;
      else        q <= nxt;
   end

   if (SO_M != '0) begin : g_so_chk
      AST_SETONLY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> ((~q & $past(q) & SO_M) == '0)); // R6
   end
   if (CO_M != '0) begin : g_co_chk
      AST_CLRONLY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> ((q & ~$past(q) & CO_M) == '0)); // R5
   end
   if (W1C_M != '0) begin : g_w1c_chk
      AST_FLAG_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         ((hw_set & W1C_M) != '0) |=> ((q & $past(hw_set) & W1C_M) == ($past(hw_set) & W1C_M))); // R7
      AST_FLAG_NO_WSET: assert property (@(posedge clk) disable iff (!rst_n)
         ((hw_set & W1C_M) == '0) |=> ((q & ~$past(q) & W1C_M) == '0)); // R7
   end
endmodule

// File: rtl/cfgreg_bank.sv
module cfgreg_bank
   import cfgreg_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              err_evt,
   output logic [31:0]       cfg_remap,
   output logic [31:0]       cfg_sys1,
   output logic [31:0]       cfg_stat,
   output logic [31:0]       cfg_sys2,
   output logic [31:0]       cfg_wprot_a,
   output logic [31:0]       cfg_key,
   output logic [31:0]       cfg_wprot_b
);
   logic [NREG-1:0] sel;
   logic            hit;
   word_t           regq [NREG];
   word_t           rd_mux;

   cfgreg_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .sel  (sel),
      .hit  (hit)
   );

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      word_t hw_i;
      assign hw_i = err_evt ? W1C_TAB[i] : '0;
      cfgreg_cell #(
         .W     (DATA_W),
         .RW_M  (RW_TAB[i]),
         .SO_M  (SO_TAB[i]),
         .CO_M  (CO_TAB[i]),
         .W1C_M (W1C_TAB[i]),
         .RST_V (RST_TAB[i])
      ) u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (bus_wr & sel[i]),
         .wdata  (bus_wdata),
         .hw_set (hw_i),
         .q      (regq[i])
      );
   end

   always_comb begin
      rd_mux = '0;
      for (int k = 0; k < NREG; k++) begin
         if (sel[k]) rd_mux = rd_mux | regq[k];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= bus_rd ? rd_mux : '0;
   end

   assign cfg_remap   = regq[IX_REMAP];
   assign cfg_sys1    = regq[IX_SYS1];
   assign cfg_stat    = regq[IX_STAT];
   assign cfg_sys2    = regq[IX_SYS2];
   assign cfg_wprot_a = regq[IX_WPA];
   assign cfg_key     = regq[IX_KEY];
   assign cfg_wprot_b = regq[IX_WPB];

   AST_RD_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !hit) |=> (bus_rdata == '0)); // R11
   AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == '0)); // R2
   AST_REMAP_RSV: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && sel[IX_REMAP]) |=> ((bus_rdata & ~32'h0000_0107) == '0)); // R3
   AST_WPROT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~cfg_wprot_b & $past(cfg_wprot_b)) == '0)); // R8
endmodule

// File: tb/tb_cfgreg_bank.sv
`timescale 1ns/1ps
module tb_cfgreg_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        err_evt = 1'b0;
   logic [31:0] cfg_remap, cfg_sys1, cfg_stat, cfg_sys2, cfg_wprot_a, cfg_key, cfg_wprot_b;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   cfgreg_bank #(.ADDR_W(8)) dut (
      .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata, .err_evt,
      .cfg_remap, .cfg_sys1, .cfg_stat, .cfg_sys2, .cfg_wprot_a, .cfg_key, .cfg_wprot_b
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(req, d, exp);
   endtask

   task automatic t_reset();
      rd_chk("R1 remap",  8'h00, 32'h0);
      rd_chk("R1 sys1",   8'h04, 32'h7C00_0001);
      rd_chk("R1 stat",   8'h18, 32'h0);
      rd_chk("R1 sys2",   8'h1C, 32'h0);
      rd_chk("R1 wprotA", 8'h20, 32'h0);
      rd_chk("R1 key",    8'h24, 32'h0);
      rd_chk("R1 wprotB", 8'h28, 32'h0);
      chk("R12 sys1 port at reset", cfg_sys1, 32'h7C00_0001);
   endtask

   task automatic t_readlat();
      logic [31:0] d;
      rd(8'h04, d);
      chk("R2 read data one cycle later", d, 32'h7C00_0001);
      @(negedge clk);
      chk("R2 idle read data zero", bus_rdata, 32'h0);
   endtask

   task automatic t_remap();
      wr(8'h00, 32'hFFFF_FFFF);
      rd_chk("R3 remap all ones", 8'h00, 32'h0000_0107);
      chk("R12 remap port", cfg_remap, 32'h0000_0107);
      wr(8'h00, 32'h0000_0000);
      rd_chk("R3 remap cleared", 8'h00, 32'h0);
   endtask

   task automatic t_sys1();
      wr(8'h04, 32'hFFFF_FFFF);
      rd_chk("R4 sys1 all ones", 8'h04, 32'hFCFF_0101);
      wr(8'h04, 32'h0000_0001);
      rd_chk("R4 sys1 upper bits cleared", 8'h04, 32'h0000_0001);
      wr(8'h04, 32'h0000_0000);
      rd_chk("R5 sys1 bit0 cleared", 8'h04, 32'h0);
      wr(8'h04, 32'h0000_0001);
      rd_chk("R5 sys1 bit0 cannot be set", 8'h04, 32'h0);
      chk("R12 sys1 port", cfg_sys1, 32'h0);
   endtask

   task automatic t_sys2();
      wr(8'h1C, 32'h0000_0005);
      rd_chk("R6 sys2 set 5", 8'h1C, 32'h5);
      wr(8'h1C, 32'h0000_000A);
      rd_chk("R6 sys2 accumulate", 8'h1C, 32'hF);
      wr(8'h1C, 32'h0000_0000);
      rd_chk("R6 sys2 zero write keeps", 8'h1C, 32'hF);
      wr(8'h1C, 32'h0000_0100);
      rd_chk("R7 flag not set by write", 8'h1C, 32'hF);
      @(negedge clk); err_evt = 1'b1;
      @(negedge clk); err_evt = 1'b0;
      rd_chk("R7 flag set by pulse", 8'h1C, 32'h10F);
      wr(8'h1C, 32'h0000_0100);
      rd_chk("R7 flag cleared by one", 8'h1C, 32'hF);
      @(negedge clk);
      err_evt = 1'b1; bus_addr = 8'h1C; bus_wdata = 32'h100; bus_wr = 1'b1;
      @(negedge clk);
      err_evt = 1'b0; bus_wr = 1'b0;
      rd_chk("R7 hardware set wins", 8'h1C, 32'h10F);
      chk("R12 sys2 port", cfg_sys2, 32'h10F);
   endtask

   task automatic t_wprot();
      wr(8'h20, 32'hFFFF_FFFF);
      wr(8'h20, 32'h0000_0000);
      rd_chk("R8 wprotA sticky", 8'h20, 32'hFFFF_FFFF);
      wr(8'h28, 32'h1234_5678);
      wr(8'h28, 32'h8000_0000);
      rd_chk("R8 wprotB accumulate", 8'h28, 32'h9234_5678);
      wr(8'h28, 32'h0000_0000);
      rd_chk("R8 wprotB sticky", 8'h28, 32'h9234_5678);
   endtask

   task automatic t_key_stat();
      wr(8'h24, 32'hFFFF_FFFF);
      rd_chk("R9 key masked", 8'h24, 32'h0000_00FF);
      wr(8'h24, 32'h0000_005A);
      rd_chk("R9 key value", 8'h24, 32'h0000_005A);
      wr(8'h18, 32'hFFFF_FFFF);
      rd_chk("R10 stat masked", 8'h18, 32'h1);
      wr(8'h18, 32'h0);
      rd_chk("R10 stat cleared", 8'h18, 32'h0);
   endtask

   task automatic t_unmapped();
      wr(8'h08, 32'hFFFF_FFFF);
      wr(8'h25, 32'hFFFF_FFFF);
      wr(8'h2C, 32'hFFFF_FFFF);
      wr(8'hFC, 32'hFFFF_FFFF);
      rd_chk("R11 read 0x08", 8'h08, 32'h0);
      rd_chk("R11 read 0x14", 8'h14, 32'h0);
      rd_chk("R11 read 0x2C", 8'h2C, 32'h0);
      rd_chk("R11 read misaligned", 8'h25, 32'h0);
      rd_chk("R11 key untouched", 8'h24, 32'h0000_005A);
      rd_chk("R11 stat untouched", 8'h18, 32'h0);
      chk("R11 remap port untouched", cfg_remap, 32'h0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            t_reset();
            t_readlat();
            t_remap();
            t_sys1();
            t_sys2();
            t_wprot();
            t_key_stat();
            t_unmapped();
         end
         begin
            repeat (5000) @(posedge clk);
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule